// File: doc/BRIEF.md
# Zero-Turnaround Synchronous SRAM Core

This block is a synthesizable model of a synchronous static RAM whose data bus can switch between reads and writes on every clock cycle with no idle cycle between them. Commands (address, read/write select, byte enables, chip selects, burst control) are sampled on the rising clock edge. Write data lags its command by a fixed latency (late write), so the core keeps the write address and byte enables of each pending write in a short shift register and commits the write at the edge where its data arrives. A read that overtakes such a pending write still returns the newest data, merged byte by byte.

A static mode input picks one of two read timings. In flow-through mode read data comes straight from the array and write data trails its command by one edge. In pipelined mode read data passes through an output register and write data trails by two edges. A burst controller steps the two low address bits in linear or interleaved order. Its state machine has three states: `ST_IDLE` (no burst open), `ST_RBURST` (read burst open) and `ST_WBURST` (write burst open). A load cycle moves any state to `ST_RBURST` or `ST_WBURST`, depending on the write select. An advance cycle keeps `ST_RBURST` or `ST_WBURST` and steps the counter. A deselect cycle returns any state to `ST_IDLE`. While sleep is high the state is frozen. An output enable and a sleep input act on the data outputs without waiting for a clock edge.

Top module: `zt_sram`

## Requirements
- R1: On a rising edge with `sleep` low and `adv` low, a command is accepted only when all three `cs` bits are 1. `we`=1 starts a write and `we`=0 starts a read. If any `cs` bit is 0 the cycle is a deselect: nothing is written or read, and any open burst is closed.
- R2: With `pipe_mode`=0, read data for a command captured at edge N is on `dq` with `dq_en`=1 from edge N until edge N+1.
- R3: With `pipe_mode`=1, read data for a command captured at edge N is on `dq` with `dq_en`=1 from edge N+1 until edge N+2.
- R4: Write data for a write command captured at edge N is taken from `wdata` at edge N+1 when `pipe_mode`=0, and at edge N+2 when `pipe_mode`=1.
- R5: Byte i of a word is bits [9i+8:9i]. A write changes byte i only when `be[i]` was 1 in the command cycle. All other bytes keep their old value.
- R6: Reads and writes may follow each other in any order on consecutive cycles. A read returns the result of every write commanded before it, including writes whose data has not yet arrived, merged per byte.
- R7: A cycle with `adv`=1 continues the burst opened by the last load, with the same direction, whatever the state of `cs` and `we`. With no burst open, an advance cycle does nothing.
- R8: Each advance adds 1 to a 2-bit burst count. The two low address bits become (start + count) mod 4 when `burst_ilv`=0, and start XOR count when `burst_ilv`=1. The upper address bits stay those of the start address.
- R9: While `oe` is 0, `dq_en` is 0 and `dq` is 0 at once, without waiting for a clock edge.
- R10: While `sleep` is 1, `dq_en` is 0 at once. No command is accepted at any edge while it is high, and the burst state is kept.
- R11: After reset, `dq_en` is 0 and no burst is open, so an advance cycle does nothing.
- R12: `dq` is 0 whenever `dq_en` is 0. `dq_en` is 1 only while valid read data is being presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset of control state |
| pipe_mode | input | 1 | 1 = pipelined read, two-edge write data; 0 = flow-through, one-edge write data |
| burst_ilv | input | 1 | 1 = interleaved burst order, 0 = linear |
| cs | input | NCS (3) | Chip selects, all must be 1 for a load |
| adv | input | 1 | 1 = advance burst, 0 = load or deselect |
| we | input | 1 | 1 = write command, 0 = read command |
| be | input | NBYTE (2) | Per-byte write enables, sampled with the command |
| addr | input | ADDR_W (6) | Word address |
| wdata | input | DW (18) | Late write data |
| oe | input | 1 | Asynchronous output enable |
| sleep | input | 1 | Asynchronous power-down request |
| dq | output | DW (18) | Read data, 0 when not driven |
| dq_en | output | 1 | Output drive enable (tri-state control) |

## Verification
A flow-through read is due on the first falling edge after the edge that captured it. A pipelined read is due on the second. The bench records each expected word in a slot indexed by that due cycle, and every falling edge either compares the slot or requires `dq_en` low. Write data is placed in a schedule indexed by the capture edge one or two cycles after the command, so the design sees it exactly on its late-write edge. The bench changes `oe` and `sleep` in the middle of a cycle and checks the outputs 1 ns later, with no clock edge in between, to show that both act without a clock.

// File: rtl/zt_pkg.sv
package zt_pkg;

    localparam int BURST_W = 2;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RBURST = 2'd1,
        ST_WBURST = 2'd2
    } burst_st_e;

    // Low address bits for a given burst count
    function automatic logic [BURST_W-1:0] burst_low(
        input logic [BURST_W-1:0] start,
        input logic [BURST_W-1:0] cnt,
        input logic               ilv
    );
        logic [BURST_W-1:0] r;
        if (ilv) r = start ^ cnt;
        else     r = start + cnt;
        return r;
    endfunction

endpackage

// File: rtl/zt_burst_ctl.sv
module zt_burst_ctl
    import zt_pkg::*;
#(
    parameter int AW  = 6,
    parameter int NCS = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sleep,
    input  logic [NCS-1:0] cs,
    input  logic          adv,
    input  logic          we,
    input  logic          ilv,
    input  logic [AW-1:0] addr,
    output logic          op_rd,
    output logic          op_wr,
    output logic [AW-1:0] op_addr
);

    burst_st_e          st, st_nxt;
    logic [AW-1:0]      base, base_nxt;
    logic [BURST_W-1:0] cnt, cnt_nxt;
    logic [BURST_W-1:0] cnt_inc;
    logic [AW-1:0]      step_addr;
    logic               sel;

    assign sel       = &cs;
    assign cnt_inc   = cnt + 1'b1;
    assign step_addr = {base[AW-1:BURST_W], burst_low(base[BURST_W-1:0], cnt_inc, ilv)};

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st   <= ST_IDLE;
            base <= '0;
            cnt  <= '0;
        end else begin
            st   <= st_nxt;
            base <= base_nxt;
            cnt  <= cnt_nxt;
        end
    end

    // Transitions and per-cycle operation
    always_comb begin
        st_nxt   = st;
        base_nxt = base;
        cnt_nxt  = cnt;
        op_rd    = 1'b0;
        op_wr    = 1'b0;
        op_addr  = base;
        if (!sleep) begin
            if (!adv) begin
                if (sel) begin
                    base_nxt = addr;
                    cnt_nxt  = '0;
                    op_addr  = addr;
                    op_wr    = we;
                    op_rd    = !we;
                    st_nxt   = we ? ST_WBURST : ST_RBURST;
                end else begin
                    st_nxt = ST_IDLE;
                end
            end else begin
                unique case (st)
                    ST_IDLE: begin
                        st_nxt = ST_IDLE;
                    end
                    ST_RBURST: begin
                        cnt_nxt = cnt_inc;
                        op_addr = step_addr;
                        op_rd   = 1'b1;
                    end
                    ST_WBURST: begin
                        cnt_nxt = cnt_inc;
                        op_addr = step_addr;
                        op_wr   = 1'b1;
                    end
                    default: begin
                        st_nxt = ST_IDLE;
                    end
                endcase
            end
        end
    end

    // R1: deselect closes the burst
    a_r1_deselect_closes: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep && !adv && !(&cs)) |=> (st == ST_IDLE));

    // R10: sleep freezes burst state
    a_r10_sleep_holds: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |=> ($stable(st) && $stable(base) && $stable(cnt)));

    // R7: advance with no open burst issues nothing
    a_r7_adv_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && adv) |-> !(op_rd || op_wr));

    // R8: consecutive linear read advances step the low bits by one
    a_r8_linear_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep && adv && !ilv && st == ST_RBURST && $past(!sleep && adv && op_rd))
        |-> (op_addr[BURST_W-1:0] == BURST_W'($past(op_addr[BURST_W-1:0]) + 1'b1)));

endmodule

// File: rtl/zt_wr_pipe.sv
module zt_wr_pipe #(
    parameter int AW  = 6,
    parameter int NB  = 2,
    parameter int LAT = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode_pipe,
    input  logic          op_wr,
    input  logic [AW-1:0] op_addr,
    input  logic [NB-1:0] op_be,
    output logic          cm_en,
    output logic [AW-1:0] cm_addr,
    output logic [NB-1:0] cm_be
);

    typedef struct packed {
        logic          v;
        logic [AW-1:0] a;
        logic [NB-1:0] be;
    } wr_slot_t;

    wr_slot_t stg [LAT];
    wr_slot_t pick;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < LAT; i++) stg[i] <= '0;
        end else begin
            stg[0] <= '{v: op_wr, a: op_addr, be: op_be};
            for (int i = 1; i < LAT; i++) stg[i] <= stg[i-1];
        end
    end

    // Flow-through commits from the first slot, pipelined from the last
    assign pick    = mode_pipe ? stg[LAT-1] : stg[0];
    assign cm_en   = pick.v;
    assign cm_addr = pick.a;
    assign cm_be   = pick.be;

    // R4: commit in flow-through matches a write one edge earlier
    a_r4_flow_src: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_pipe && cm_en) |-> ($past(op_wr) && cm_addr == $past(op_addr)));

    // R4: commit in pipelined mode matches a write two edges earlier
    a_r4_pipe_src: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_pipe && cm_en) |-> ($past(op_wr, 2) && cm_addr == $past(op_addr, 2)));

endmodule

// File: rtl/zt_mem.sv
module zt_mem #(
    parameter int AW = 6,
    parameter int NB = 2,
    parameter int BW = 9
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [NB-1:0]    wr_be,
    input  logic [NB*BW-1:0] wr_data,
    input  logic [AW-1:0]    rd_addr,
    output logic [NB*BW-1:0] rd_data
);

    localparam int DEPTH = 1 << AW;

    for (genvar b = 0; b < NB; b++) begin : g_lane
        logic [BW-1:0] cells [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_en && wr_be[b]) cells[wr_addr] <= wr_data[b*BW +: BW];
        end

        assign rd_data[b*BW +: BW] = cells[rd_addr];
    end

endmodule

// File: rtl/zt_rd_path.sv
module zt_rd_path #(
    parameter int AW = 6,
    parameter int NB = 2,
    parameter int BW = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_pipe,
    input  logic             op_rd,
    input  logic [AW-1:0]    op_addr,
    output logic [AW-1:0]    rd_addr,
    input  logic [NB*BW-1:0] mem_q,
    input  logic             cm_en,
    input  logic [AW-1:0]    cm_addr,
    input  logic [NB-1:0]    cm_be,
    input  logic [NB*BW-1:0] cm_data,
    output logic [NB*BW-1:0] out_data,
    output logic             out_vld
);

    logic             ra_v;
    logic [AW-1:0]    ra;
    logic             qv;
    logic [NB*BW-1:0] q;
    logic [NB*BW-1:0] fwd_q;

    // Merge the write committing at this edge into the registered read word
    always_comb begin
        fwd_q = mem_q;
        if (cm_en && cm_addr == ra) begin
            for (int b = 0; b < NB; b++) begin
                if (cm_be[b]) fwd_q[b*BW +: BW] = cm_data[b*BW +: BW];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ra_v <= 1'b0;
            ra   <= '0;
            qv   <= 1'b0;
            q    <= '0;
        end else begin
            ra_v <= op_rd;
            ra   <= op_addr;
            qv   <= ra_v;
            q    <= fwd_q;
        end
    end

    assign rd_addr  = ra;
    assign out_data = mode_pipe ? q : mem_q;
    assign out_vld  = mode_pipe ? qv : ra_v;

    // R6: a full-word write landing with a pipelined read of its address is returned
    a_r6_forward: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_pipe && ra_v && cm_en && cm_addr == ra && cm_be == {NB{1'b1}})
        |=> (q == $past(cm_data)));

    // R3: the output register follows the captured read by one edge
    a_r3_reg_follow: assert property (@(posedge clk) disable iff (!rst_n)
        ra_v |=> qv);

endmodule

// File: rtl/zt_sram.sv
module zt_sram
    import zt_pkg::*;
#(
    parameter  int ADDR_W = 6,
    parameter  int NBYTE  = 2,
    parameter  int BYTE_W = 9,
    parameter  int NCS    = 3,
    localparam int DW     = NBYTE * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pipe_mode,
    input  logic              burst_ilv,
    input  logic [NCS-1:0]    cs,
    input  logic              adv,
    input  logic              we,
    input  logic [NBYTE-1:0]  be,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DW-1:0]     wdata,
    input  logic              oe,
    input  logic              sleep,
    output logic [DW-1:0]     dq,
    output logic              dq_en
);

    localparam int WR_LAT = 2;

    logic              op_rd, op_wr;
    logic [ADDR_W-1:0] op_addr;
    logic              cm_en;
    logic [ADDR_W-1:0] cm_addr;
    logic [NBYTE-1:0]  cm_be;
    logic [ADDR_W-1:0] rd_addr;
    logic [DW-1:0]     mem_q;
    logic [DW-1:0]     rd_data;
    logic              rd_vld;

    zt_burst_ctl #(.AW(ADDR_W), .NCS(NCS)) u_ctl (
        .clk     (clk),
        .rst_n   (rst_n),
        .sleep   (sleep),
        .cs      (cs),
        .adv     (adv),
        .we      (we),
        .ilv     (burst_ilv),
        .addr    (addr),
        .op_rd   (op_rd),
        .op_wr   (op_wr),
        .op_addr (op_addr)
    );

    zt_wr_pipe #(.AW(ADDR_W), .NB(NBYTE), .LAT(WR_LAT)) u_wpipe (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_pipe (pipe_mode),
        .op_wr     (op_wr),
        .op_addr   (op_addr),
        .op_be     (be),
        .cm_en     (cm_en),
        .cm_addr   (cm_addr),
        .cm_be     (cm_be)
    );

    zt_mem #(.AW(ADDR_W), .NB(NBYTE), .BW(BYTE_W)) u_mem (
        .clk     (clk),
        .wr_en   (cm_en),
        .wr_addr (cm_addr),
        .wr_be   (cm_be),
        .wr_data (wdata),
        .rd_addr (rd_addr),
        .rd_data (mem_q)
    );

    zt_rd_path #(.AW(ADDR_W), .NB(NBYTE), .BW(BYTE_W)) u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_pipe (pipe_mode),
        .op_rd     (op_rd),
        .op_addr   (op_addr),
        .rd_addr   (rd_addr),
        .mem_q     (mem_q),
        .cm_en     (cm_en),
        .cm_addr   (cm_addr),
        .cm_be     (cm_be),
        .cm_data   (wdata),
        .out_data  (rd_data),
        .out_vld   (rd_vld)
    );

    // Asynchronous output gating
    assign dq_en = oe & ~sleep & rd_vld;
    assign dq    = dq_en ? rd_data : '0;

    // R2: flow-through read is presented after its own capture edge
    a_r2_flow_due: assert property (@(posedge clk) disable iff (!rst_n)
        (!pipe_mode && op_rd) |=> rd_vld);

    // R3: pipelined read is presented one edge later
    a_r3_pipe_due: assert property (@(posedge clk) disable iff (!rst_n)
        (pipe_mode && op_rd) |-> ##2 rd_vld);

endmodule

// File: tb/tb_zt_sram.sv
`timescale 1ns/1ps
module tb_zt_sram;

    localparam int AW = 6;
    localparam int DW = 18;
    localparam int NV = 20;
    localparam int NS = 256;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          pipe_mode, burst_ilv, adv, we, oe, sleep;
    logic [2:0]    cs;
    logic [1:0]    be;
    logic [AW-1:0] addr;
    logic [DW-1:0] wdata;
    logic [DW-1:0] dq;
    logic          dq_en;

    always #4 clk = ~clk;

    zt_sram dut (
        .clk(clk), .rst_n(rst_n), .pipe_mode(pipe_mode), .burst_ilv(burst_ilv),
        .cs(cs), .adv(adv), .we(we), .be(be), .addr(addr), .wdata(wdata),
        .oe(oe), .sleep(sleep), .dq(dq), .dq_en(dq_en)
    );

    // {tag[4], adv, we, cs_on, addr[6], be[2], data[18]}
    localparam logic [32:0] VEC [NV] = '{
        {4'd4,  1'b0, 1'b1, 1'b1, 6'd4, 2'b11, 18'h12345},
        {4'd6,  1'b0, 1'b0, 1'b1, 6'd4, 2'b11, 18'h00000},
        {4'd5,  1'b0, 1'b1, 1'b1, 6'd4, 2'b01, 18'h3ABCD},
        {4'd5,  1'b0, 1'b0, 1'b1, 6'd4, 2'b11, 18'h00000},
        {4'd7,  1'b0, 1'b1, 1'b1, 6'd0, 2'b11, 18'h00A01},
        {4'd7,  1'b1, 1'b0, 1'b1, 6'd0, 2'b11, 18'h00B02},
        {4'd7,  1'b1, 1'b0, 1'b0, 6'd0, 2'b11, 18'h00C03},
        {4'd7,  1'b1, 1'b0, 1'b1, 6'd0, 2'b11, 18'h00D04},
        {4'd8,  1'b0, 1'b0, 1'b1, 6'd1, 2'b11, 18'h00000},
        {4'd8,  1'b1, 1'b0, 1'b1, 6'd1, 2'b11, 18'h00000},
        {4'd8,  1'b1, 1'b1, 1'b0, 6'd1, 2'b11, 18'h00000},
        {4'd8,  1'b1, 1'b0, 1'b1, 6'd1, 2'b11, 18'h00000},
        {4'd1,  1'b0, 1'b1, 1'b0, 6'd4, 2'b11, 18'h3FFFF},
        {4'd7,  1'b1, 1'b1, 1'b0, 6'd4, 2'b11, 18'h3FFFF},
        {4'd1,  1'b0, 1'b0, 1'b1, 6'd4, 2'b11, 18'h00000},
        {4'd4,  1'b0, 1'b1, 1'b1, 6'd9, 2'b11, 18'h15555},
        {4'd5,  1'b0, 1'b1, 1'b1, 6'd9, 2'b10, 18'h2AAAA},
        {4'd6,  1'b0, 1'b0, 1'b1, 6'd9, 2'b11, 18'h00000},
        {4'd2,  1'b0, 1'b0, 1'b1, 6'd0, 2'b11, 18'h00000},
        {4'd12, 1'b0, 1'b0, 1'b0, 6'd0, 2'b11, 18'h00000}
    };

    int total = 0;
    int fails = 0;
    int cyc   = 0;
    bit done  = 1'b0;

    logic [DW-1:0] model  [1<<AW];
    logic [DW-1:0] wsched [NS];
    logic [DW-1:0] exp_d  [NS];
    logic          exp_v  [NS];
    int            tag_at [NS];

    logic       b_act, b_we;
    logic [5:0] b_base;
    logic [1:0] b_cnt;

    function automatic string rname(input int t);
        case (t)
            1:  return "R1";
            2:  return "R2";
            3:  return "R3";
            4:  return "R4";
            5:  return "R5";
            6:  return "R6";
            7:  return "R7";
            8:  return "R8";
            9:  return "R9";
            10: return "R10";
            11: return "R11";
            default: return "R12";
        endcase
    endfunction

    task automatic check(input logic ok, input int t, input logic [DW:0] act, input logic [DW:0] expv);
        total++;
        if (ok !== 1'b1) begin
            fails++;
            $display("FAIL %s: got en/data %h expected %h", rname(t), act, expv);
        end
    endtask

    task automatic verify();
        int t;
        t = tag_at[cyc];
        if (exp_v[cyc]) begin
            if (pipe_mode && t == 2) t = 3;
            check(dq_en === 1'b1 && dq === exp_d[cyc], t, {dq_en, dq}, {1'b1, exp_d[cyc]});
        end else begin
            check(dq_en === 1'b0 && dq === '0, t, {dq_en, dq}, '0);
        end
    endtask

    // One command cycle; bench keeps its own burst and memory model
    task automatic issue(input logic a_adv, input logic a_we, input logic a_cs, input logic a_slp,
                         input logic [5:0] a_addr, input logic [1:0] a_be,
                         input logic [DW-1:0] a_d, input int a_tag);
        int lat;
        logic op_r, op_w;
        logic [5:0] oa;
        lat   = pipe_mode ? 2 : 1;
        adv   = a_adv;
        we    = a_we;
        cs    = a_cs ? 3'b111 : 3'b011;
        sleep = a_slp;
        addr  = a_addr;
        be    = a_be;
        wdata = wsched[cyc];
        op_r  = 1'b0;
        op_w  = 1'b0;
        oa    = a_addr;
        if (!a_slp) begin
            if (!a_adv) begin
                if (a_cs) begin
                    b_act = 1'b1; b_we = a_we; b_base = a_addr; b_cnt = 2'd0;
                    op_w = a_we; op_r = !a_we;
                end else begin
                    b_act = 1'b0;
                end
            end else if (b_act) begin
                b_cnt = b_cnt + 2'd1;
                oa = {b_base[5:2], burst_ilv ? (b_base[1:0] ^ b_cnt) : 2'(b_base[1:0] + b_cnt)};
                op_w = b_we; op_r = !b_we;
            end
        end
        if (op_w) begin
            for (int b = 0; b < 2; b++) if (a_be[b]) model[oa][b*9 +: 9] = a_d[b*9 +: 9];
            wsched[cyc+lat] = a_d;
        end
        if (op_r) begin
            exp_d[cyc+lat] = model[oa];
            exp_v[cyc+lat] = 1'b1;
        end
        tag_at[cyc+lat] = a_tag;
        @(posedge clk);
        @(negedge clk);
        cyc++;
        verify();
    endtask

    task automatic drain(input int n);
        for (int k = 0; k < n; k++) issue(1'b0, 1'b0, 1'b0, 1'b0, 6'd0, 2'b00, '0, 12);
    endtask

    task automatic walk_table();
        for (int i = 0; i < NV; i++) begin
            logic [32:0] v;
            v = VEC[i];
            issue(v[28], v[27], v[26], 1'b0, v[25:20], v[19:18], v[17:0], int'(v[32:29]));
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog: run did not complete");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NS; i++) begin
            wsched[i] = '0; exp_d[i] = '0; exp_v[i] = 1'b0; tag_at[i] = 12;
        end
        b_act = 1'b0; b_we = 1'b0; b_base = '0; b_cnt = '0;
        rst_n = 1'b0; pipe_mode = 1'b0; burst_ilv = 1'b0; adv = 1'b0; we = 1'b0;
        cs = 3'b000; be = 2'b00; addr = '0; wdata = '0; oe = 1'b1; sleep = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R11: nothing driven after reset
        check(dq_en === 1'b0 && dq === '0, 11, {dq_en, dq}, '0);
        @(negedge clk);
        // R11: advance with no burst open does nothing
        issue(1'b1, 1'b0, 1'b1, 1'b0, 6'd3, 2'b11, '0, 11);
        issue(1'b0, 1'b0, 1'b0, 1'b0, 6'd0, 2'b00, '0, 11);

        // Flow-through, linear
        walk_table();
        drain(2);

        // R9: output enable acts without a clock
        issue(1'b0, 1'b0, 1'b1, 1'b0, 6'd4, 2'b11, '0, 2);
        oe = 1'b0;
        #1;
        check(dq_en === 1'b0 && dq === '0, 9, {dq_en, dq}, '0);
        oe = 1'b1;
        #1;
        check(dq_en === 1'b1 && dq === model[4], 9, {dq_en, dq}, {1'b1, model[4]});
        drain(1);

        // R10: sleep gates the outputs and blocks a write
        issue(1'b0, 1'b0, 1'b1, 1'b0, 6'd0, 2'b11, '0, 2);
        sleep = 1'b1;
        #1;
        check(dq_en === 1'b0, 10, {dq_en, dq}, '0);
        issue(1'b0, 1'b1, 1'b1, 1'b1, 6'd0, 2'b11, 18'h3FFFF, 10);
        issue(1'b0, 1'b0, 1'b0, 1'b0, 6'd0, 2'b00, '0, 10);
        issue(1'b0, 1'b0, 1'b1, 1'b0, 6'd0, 2'b11, '0, 10);
        drain(3);

        // Pipelined, interleaved
        pipe_mode = 1'b1;
        burst_ilv = 1'b1;
        drain(2);
        walk_table();
        drain(3);

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule